// File: doc/BRIEF.md
# USB Bulk IN Packet Segmenter

This block turns one bulk IN transfer into a sequence of USB data packets for a single endpoint. Software programs a 2-bit packet size code while the block is idle, then issues a start strobe together with a 16-bit transfer length. Bytes arrive on a valid/ready input stream. They are cut into packets of the endpoint's maximum size, and any remainder goes into one final short packet. When the length is an exact multiple of the maximum size, including a length of zero, a zero-length packet closes the transfer.

Two packet buffers work in ping-pong fashion. One buffer can wait for the host while the other fills, so a finished packet is normally ready when the host asks for one. A one-cycle host request strobe starts the transmission of the oldest ready packet on a byte-wide output, with a marker on the final byte. A zero-length packet is signalled by its own one-cycle strobe and carries no data. If the host asks when no packet is ready, the block answers with a one-cycle NAK. Three single-cycle events report progress: a packet was sent, the programmed byte count was used up, and the transfer completed.

The controller has four states:
- `ST_IDLE`: no transfer is in progress.
- `ST_WAIT`: a transfer is active and the block waits for a host request.
- `ST_SEND`: a data packet is streaming out.
- `ST_ZLP`: the zero-length packet is being signalled.

The transitions are:
- IDLE→WAIT on start.
- WAIT→SEND on a request when the ready packet holds data.
- WAIT→ZLP on a request when the ready packet is empty.
- SEND→WAIT after the last byte of a full packet.
- SEND→IDLE after the last byte of a short packet.
- ZLP→IDLE unconditionally.
- Any state→IDLE on abort.

Top module: `usb_bulk_in_segmenter`

## Requirements
- R1: The size code selects the maximum packet length: 0 gives 8 bytes, 1 gives 16, 2 gives 32 and 3 gives 64.
- R2: A size-code write takes effect only in ST_IDLE. Writes made during a transfer are ignored, and packet lengths follow the code held at start.
- R3: The transfer is sent in order as packets of the maximum length followed by one shorter packet holding the remainder. Each data byte goes out one per cycle with `tx_valid`, and `tx_last` marks the final byte of each packet.
- R4: A packet shorter than the maximum ends the transfer. The block returns to ST_IDLE, and later host requests produce no further packets.
- R5: When the length is a nonzero multiple of the maximum, one zero-length packet follows the last full packet. It is signalled by `tx_zlp` for one cycle with `tx_valid` low.
- R6: `ev_pkt_done` pulses once per packet, in the cycle of the packet's last byte or of its `tx_zlp` strobe.
- R7: `ev_bytes_done` pulses exactly once per transfer. It pulses one cycle after the clock edge that accepts the final input byte, or one cycle after start when the length is zero.
- R8: `ev_xfer_done` pulses exactly once per transfer, together with `ev_pkt_done` for the final short or zero-length packet.
- R9: With no host requests, the block accepts up to twice the maximum packet length ahead of transmission before it stops accepting input.
- R10: A length of zero produces exactly one zero-length packet and then completes the transfer.
- R11: A host request in ST_WAIT with no ready packet gives a one-cycle `nak` and starts no transmission.
- R12: `in_ready` is low when both buffers hold packets, when every byte of the transfer has been accepted, and whenever the block is idle.
- R13: Abort clears both buffers and returns the block to ST_IDLE in the next cycle, without raising `ev_xfer_done`. A following transfer runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_code | input | 2 | Maximum packet size code |
| cfg_size_we | input | 1 | Size code write strobe (honoured only in ST_IDLE) |
| start | input | 1 | Begins a transfer and loads its length |
| xfer_len | input | LEN_W | Transfer length in bytes |
| abort | input | 1 | Cancels the transfer and returns to idle |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| host_req | input | 1 | Host request strobe for one packet |
| tx_data | output | 8 | Outgoing packet byte |
| tx_valid | output | 1 | `tx_data` carries a packet byte |
| tx_last | output | 1 | Final byte of the current packet |
| tx_zlp | output | 1 | Zero-length packet strobe |
| nak | output | 1 | Request refused because no packet is ready |
| ev_pkt_done | output | 1 | A packet has been sent |
| ev_bytes_done | output | 1 | Programmed byte count is used up |
| ev_xfer_done | output | 1 | Transfer completed |
| busy | output | 1 | A transfer is active |

## Verification
The `nak` output and the in_ready decision depend combinationally on the request or data presented in the same cycle. The bench therefore drives inputs just after a rising edge and samples all outputs at the falling edge of that same cycle. The first data byte appears in the cycle after the edge that samples `host_req`, and byte k follows k cycles later. `ev_pkt_done`, `ev_xfer_done` and `tx_zlp` coincide with the final byte or the zero-length strobe. `ev_bytes_done` is registered, so the bench looks for it at the falling edge that follows the edge accepting the final byte. After an abort, the bench expects `busy` and `in_ready` to be low at the very next falling edge.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int PKT_MAX_BYTES = 64;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } sz_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND,
        ST_ZLP
    } seg_state_e;
endpackage

// File: rtl/seg_pkt_buf.sv
module seg_pkt_buf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          commit_short,
    input  logic          release_i,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          ready,
    output logic [LW-1:0] len,
    output logic          short_pkt
);
    logic [7:0] mem [DEPTH];

    // Payload storage carries no reset; only the bookkeeping flags do.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready     <= 1'b0;
            len       <= '0;
            short_pkt <= 1'b0;
        end else if (clr) begin
            ready     <= 1'b0;
        end else if (commit) begin
            ready     <= 1'b1;
            len       <= commit_len;
            short_pkt <= commit_short;
        end else if (release_i) begin
            ready     <= 1'b0;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/seg_fill.sv
module seg_fill #(
    parameter int LEN_W = 16,
    parameter int AW    = 6,
    localparam int LW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] go_len,
    input  logic             abort,
    input  logic             active,
    input  logic [LW-1:0]    max_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       buf_ready,
    output logic [1:0]       wr_en,
    output logic [AW-1:0]    wr_idx,
    output logic [1:0]       commit,
    output logic [LW-1:0]    commit_len,
    output logic             commit_short,
    output logic             bytes_done
);
    logic [LEN_W-1:0] rem_q;
    logic             sel_q;
    logic [LW-1:0]    cnt_q;
    logic [LW-1:0]    cnt_inc;
    logic             zlp_pend_q;
    logic             bytes_done_q;
    logic             free, accept, full_pkt, end_data, close, zlp_go;

    assign free     = !buf_ready[sel_q];
    assign in_ready = active && (rem_q != '0) && free;
    assign accept   = in_valid && in_ready;
    assign cnt_inc  = cnt_q + 1'b1;
    assign full_pkt = (cnt_inc == max_len);
    assign end_data = (rem_q == LEN_W'(1));
    assign close    = accept && (full_pkt || end_data);
    assign zlp_go   = active && (rem_q == '0) && zlp_pend_q && free;

    for (genvar g = 0; g < 2; g++) begin : g_route
        assign wr_en[g]  = accept && (sel_q == 1'(g));
        assign commit[g] = (close || zlp_go) && (sel_q == 1'(g));
    end

    assign wr_idx       = cnt_q[AW-1:0];
    assign commit_len   = zlp_go ? '0 : cnt_inc;
    assign commit_short = zlp_go || !full_pkt;
    assign bytes_done   = bytes_done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q        <= '0;
            sel_q        <= 1'b0;
            cnt_q        <= '0;
            zlp_pend_q   <= 1'b0;
            bytes_done_q <= 1'b0;
        end else begin
            bytes_done_q <= (go && (go_len == '0)) ||
                            (accept && end_data && !abort);
            if (abort) begin
                rem_q      <= '0;
                sel_q      <= 1'b0;
                cnt_q      <= '0;
                zlp_pend_q <= 1'b0;
            end else if (go) begin
                rem_q      <= go_len;
                sel_q      <= 1'b0;
                cnt_q      <= '0;
                zlp_pend_q <= 1'b1;
            end else begin
                if (accept) begin
                    rem_q <= rem_q - 1'b1;
                    cnt_q <= close ? '0 : cnt_inc;
                    if (close) begin
                        sel_q <= ~sel_q;
                    end
                    if (close && !full_pkt) begin
                        zlp_pend_q <= 1'b0;
                    end
                end
                if (zlp_go) begin
                    zlp_pend_q <= 1'b0;
                    sel_q      <= ~sel_q;
                end
            end
        end
    end
endmodule

// File: rtl/usb_bulk_in_segmenter.sv
module usb_bulk_in_segmenter
    import seg_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_size_code,
    input  logic             cfg_size_we,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             abort,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             host_req,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             tx_zlp,
    output logic             nak,
    output logic             ev_pkt_done,
    output logic             ev_bytes_done,
    output logic             ev_xfer_done,
    output logic             busy
);
    localparam int AW = $clog2(PKT_MAX_BYTES);
    localparam int LW = AW + 1;

    seg_state_e    state_q, state_d;
    logic [1:0]    sz_q;
    logic          send_sel_q;
    logic [AW-1:0] send_idx_q;
    logic [LW-1:0] max_len;

    logic [1:0]    buf_rdy, buf_short, fill_wr, fill_commit, buf_rel;
    logic [LW-1:0] buf_len [2];
    logic [7:0]    buf_rd  [2];
    logic [AW-1:0] fill_idx;
    logic [LW-1:0] commit_len;
    logic          commit_short;

    logic          go, clr, release_pkt;
    logic          cur_rdy, cur_short, cur_last;
    logic [LW-1:0] cur_len;

    assign go      = start && (state_q == ST_IDLE) && !abort;
    assign clr     = abort || go;
    assign busy    = (state_q != ST_IDLE);
    assign max_len = LW'(8) << sz_q;

    assign cur_rdy   = buf_rdy[send_sel_q];
    assign cur_len   = buf_len[send_sel_q];
    assign cur_short = buf_short[send_sel_q];
    assign cur_last  = (({1'b0, send_idx_q} + 1'b1) == cur_len);

    for (genvar g = 0; g < 2; g++) begin : g_buf
        assign buf_rel[g] = release_pkt && (send_sel_q == 1'(g));

        seg_pkt_buf #(.DEPTH(PKT_MAX_BYTES)) u_buf (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr          (clr),
            .wr_en        (fill_wr[g]),
            .wr_idx       (fill_idx),
            .wr_data      (in_data),
            .commit       (fill_commit[g]),
            .commit_len   (commit_len),
            .commit_short (commit_short),
            .release_i    (buf_rel[g]),
            .rd_idx       (send_idx_q),
            .rd_data      (buf_rd[g]),
            .ready        (buf_rdy[g]),
            .len          (buf_len[g]),
            .short_pkt    (buf_short[g])
        );
    end

    seg_fill #(.LEN_W(LEN_W), .AW(AW)) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .go_len       (xfer_len),
        .abort        (abort),
        .active       (busy),
        .max_len      (max_len),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .buf_ready    (buf_rdy),
        .wr_en        (fill_wr),
        .wr_idx       (fill_idx),
        .commit       (fill_commit),
        .commit_len   (commit_len),
        .commit_short (commit_short),
        .bytes_done   (ev_bytes_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Size code, read pointer and read index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sz_q       <= SZ_8;
            send_sel_q <= 1'b0;
            send_idx_q <= '0;
        end else begin
            if (cfg_size_we && (state_q == ST_IDLE)) begin
                sz_q <= cfg_size_code;
            end
            if (clr) begin
                send_sel_q <= 1'b0;
            end else if (release_pkt) begin
                send_sel_q <= ~send_sel_q;
            end
            if (state_q == ST_SEND) begin
                send_idx_q <= send_idx_q + 1'b1;
            end else begin
                send_idx_q <= '0;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_WAIT;
            ST_WAIT: if (host_req && cur_rdy)
                         state_d = (cur_len == '0) ? ST_ZLP : ST_SEND;
            ST_SEND: if (cur_last)
                         state_d = cur_short ? ST_IDLE : ST_WAIT;
            ST_ZLP:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    // Outputs
    always_comb begin
        tx_data      = '0;
        tx_valid     = 1'b0;
        tx_last      = 1'b0;
        tx_zlp       = 1'b0;
        nak          = 1'b0;
        ev_pkt_done  = 1'b0;
        ev_xfer_done = 1'b0;
        release_pkt  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: nak = host_req && !cur_rdy;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_data  = buf_rd[send_sel_q];
                tx_last  = cur_last;
                if (cur_last) begin
                    ev_pkt_done  = 1'b1;
                    ev_xfer_done = cur_short;
                    release_pkt  = 1'b1;
                end
            end
            ST_ZLP: begin
                tx_zlp       = 1'b1;
                ev_pkt_done  = 1'b1;
                ev_xfer_done = 1'b1;
                release_pkt  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_bulk_in_segmenter_chk.sv
module usb_bulk_in_segmenter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       abort,
    input logic       busy,
    input logic       in_ready,
    input logic       tx_valid,
    input logic       tx_last,
    input logic       tx_zlp,
    input logic       nak,
    input logic       ev_pkt_done,
    input logic       ev_xfer_done,
    input logic [1:0] sz
);
    p_size_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sz));

    p_last_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_short_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_xfer_done && !abort) |=> !busy);

    p_zlp_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zlp |-> !tx_valid);

    p_pkt_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_done |-> ((tx_valid && tx_last) || tx_zlp));

    p_done_with_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_xfer_done |-> ev_pkt_done);

    p_nak_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nak |-> (!tx_valid && !tx_zlp));

    p_ready_only_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    p_abort_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !in_ready));
endmodule

bind usb_bulk_in_segmenter usb_bulk_in_segmenter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort        (abort),
    .busy         (busy),
    .in_ready     (in_ready),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_zlp       (tx_zlp),
    .nak          (nak),
    .ev_pkt_done  (ev_pkt_done),
    .ev_xfer_done (ev_xfer_done),
    .sz           (sz_q)
);

// File: tb/usb_bulk_in_segmenter_bench.sv
module usb_bulk_in_segmenter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 24681;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_size_code = '0;
    logic        cfg_size_we = 1'b0;
    logic        start = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        abort = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        host_req = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, tx_zlp, nak;
    logic        ev_pkt_done, ev_bytes_done, ev_xfer_done, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bulk_in_segmenter u_usb_bulk_in_segmenter (
        .clk(clk), .rst_n(rst_n), .cfg_size_code(cfg_size_code),
        .cfg_size_we(cfg_size_we), .start(start), .xfer_len(xfer_len),
        .abort(abort), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .host_req(host_req), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_zlp(tx_zlp), .nak(nak),
        .ev_pkt_done(ev_pkt_done), .ev_bytes_done(ev_bytes_done),
        .ev_xfer_done(ev_xfer_done), .busy(busy)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] src [0:2047];
    int   pkt_lens[$];
    logic [7:0] rx[$];
    int   cur_n = 0;
    int   ev_pkt_n = 0, ev_bytes_n = 0, ev_xfer_n = 0, nak_n = 0, zlp_n = 0, pkt_end_n = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output monitor, sampling at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                rx.push_back(tx_data);
                cur_n++;
                if (tx_last) begin
                    pkt_lens.push_back(cur_n);
                    cur_n = 0;
                    pkt_end_n++;
                end
            end
            if (tx_zlp) begin
                pkt_lens.push_back(0);
                zlp_n++;
                pkt_end_n++;
            end
            if (ev_pkt_done)   ev_pkt_n++;
            if (ev_bytes_done) ev_bytes_n++;
            if (ev_xfer_done)  ev_xfer_n++;
            if (nak)           nak_n++;
        end
    end

    task automatic clear_monitor();
        pkt_lens.delete();
        rx.delete();
        cur_n = 0; ev_pkt_n = 0; ev_bytes_n = 0; ev_xfer_n = 0;
        nak_n = 0; zlp_n = 0; pkt_end_n = 0;
    endtask

    task automatic start_xfer(input int code, input int len);
        @(posedge clk); #1;
        cfg_size_code = 2'(code);
        cfg_size_we = 1'b1;
        @(posedge clk); #1;
        cfg_size_we = 1'b0;
        clear_monitor();
        for (int i = 0; i < 2048; i++) src[i] = 8'($urandom);
        xfer_len = 16'(len);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R2: a different size code written while busy must be ignored
        cfg_size_code = 2'((code + 1) % 4);
        cfg_size_we = 1'b1;
        @(posedge clk); #1;
        cfg_size_we = 1'b0;
    endtask

    task automatic feed(input int from, input int len);
        int i;
        i = from;
        while (i < len) begin
            @(posedge clk); #1;
            in_valid = ($urandom_range(3) != 0);
            in_data  = src[i];
            @(negedge clk);
            if (in_valid && in_ready) i++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0, "R12", "in_ready after all bytes accepted", in_ready, 0);
        if (len > from)
            check(ev_bytes_done == 1'b1, "R7", "bytes_done one cycle after last accept",
                  ev_bytes_done, 1);
    endtask

    task automatic host_serve();
        int p0, n0;
        while (ev_xfer_n == 0) begin
            p0 = pkt_end_n;
            n0 = nak_n;
            repeat ($urandom_range(3)) @(posedge clk);
            @(posedge clk); #1;
            host_req = 1'b1;
            @(posedge clk); #1;
            host_req = 1'b0;
            while (nak_n == n0 && pkt_end_n == p0) @(negedge clk);
        end
    endtask

    task automatic verify(input int code, input int len);
        int mx, nf, rm, exp_n, bad, p0;
        mx = 8 << code;
        nf = len / mx;
        rm = len % mx;
        exp_n = nf + 1;
        check(pkt_lens.size() == exp_n, "R3", "packet count", pkt_lens.size(), exp_n);
        for (int k = 0; k < pkt_lens.size() && k < exp_n; k++)
            check(pkt_lens[k] == ((k < nf) ? mx : rm), "R1", "packet length",
                  pkt_lens[k], (k < nf) ? mx : rm);
        check(zlp_n == ((rm == 0) ? 1 : 0), "R5", "zero-length packet count",
              zlp_n, (rm == 0) ? 1 : 0);
        check(rx.size() == len, "R3", "bytes sent", rx.size(), len);
        bad = 0;
        for (int k = 0; k < rx.size() && k < len; k++)
            if (rx[k] != src[k]) bad++;
        check(bad == 0, "R3", "data byte mismatches", bad, 0);
        check(ev_pkt_n == exp_n, "R6", "packet events", ev_pkt_n, exp_n);
        check(ev_bytes_n == 1, "R7", "byte-count events", ev_bytes_n, 1);
        check(ev_xfer_n == 1, "R8", "completion events", ev_xfer_n, 1);
        // R4: after completion the block is idle and a request yields nothing
        p0 = pkt_end_n;
        @(posedge clk); #1;
        host_req = 1'b1;
        @(posedge clk); #1;
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R4", "busy after completion", busy, 0);
        check(pkt_end_n == p0, "R4", "packets after end", pkt_end_n, p0);
    endtask

    task automatic run(input int code, input int len);
        start_xfer(code, len);
        fork
            feed(0, len);
            host_serve();
        join
        verify(code, len);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed_v, acc, len;
        seed_v = $urandom(SEED);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R12", "reset busy", busy, 0);
        check(in_ready == 1'b0, "R12", "reset in_ready", in_ready, 0);
        check(tx_valid == 1'b0 && tx_zlp == 1'b0, "R3", "reset tx idle", tx_valid, 0);

        // R11: request before any data is buffered
        start_xfer(0, 10);
        @(posedge clk); #1;
        host_req = 1'b1;
        @(negedge clk);
        check(nak == 1'b1, "R11", "nak with no ready packet", nak, 1);
        @(posedge clk); #1;
        host_req = 1'b0;
        @(negedge clk);
        check(tx_valid == 1'b0, "R11", "no data after nak", tx_valid, 0);
        fork
            feed(0, 10);
            host_serve();
        join
        verify(0, 10);

        // R9 / R12: fill both buffers without host requests
        start_xfer(0, 40);
        acc = 0;
        for (int c = 0; c < 30; c++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = src[acc];
            @(negedge clk);
            if (in_ready) acc++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(acc == 16, "R9", "bytes buffered ahead", acc, 16);
        check(in_ready == 1'b0, "R12", "in_ready with both buffers full", in_ready, 0);
        fork
            feed(16, 40);
            host_serve();
        join
        verify(0, 40);

        // Directed corner cases
        run(3, 1044);
        run(0, 16);     // R5 exact multiple
        run(2, 0);      // R10 zero length
        check(pkt_lens.size() == 1 && zlp_n == 1, "R10", "zero length gives one empty packet",
              pkt_lens.size(), 1);
        run(1, 20);
        run(2, 64);

        // R13: abort mid-transfer
        start_xfer(1, 100);
        for (int c = 0; c < 20; c++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = src[c];
        end
        @(posedge clk); #1;
        abort = 1'b1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        abort = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R13", "busy after abort", busy, 0);
        check(in_ready == 1'b0, "R13", "in_ready after abort", in_ready, 0);
        repeat (3) @(negedge clk);
        check(ev_xfer_n == 0, "R13", "completion events after abort", ev_xfer_n, 0);
        run(1, 50);

        // Constrained random transfers
        for (int t = 0; t < 10; t++) begin
            int code;
            code = $urandom_range(3);
            if ($urandom_range(2) == 0) len = (8 << code) * $urandom_range(4);
            else len = $urandom_range(300);
            run(code, len);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule